// File: doc/BRIEF.md
# Quarter-Wave Interpolating Sine/Cosine Synthesizer

This block is a numerically controlled oscillator. A phase register advances by a tuning word on every clock. The phase then drives a small table that holds only the first quarter of a sine period. Address mirroring and sign inversion rebuild the other three quarters. Two read ports fetch neighbouring table points for a sine channel and for a cosine channel in the same cycle. The fractional phase bits then blend each pair of points linearly, so the output is smoother than a nearest-entry lookup would give.

The reset input is synchronised inside the block before it clears the phase register, the pipeline and the fill counter. After the synchronised reset falls, the pipeline fills and a valid strobe rises once the first real sample reaches the outputs. The table contents are computed at elaboration time, so no initialisation data is loaded.

Top module: `sincos_interp_dds`

## Requirements
- R1: On every clock while running, the 24-bit phase register adds the current tuning word modulo 2^24. A change to the tuning word takes effect on the next clock.
- R2: Phase bits 23:22 select the quarter. In quarter 0 the table is read forward. In quarters 1 and 3 the table is read mirrored: point index 64-a is blended toward index 63-a. In quarters 2 and 3 the result is negated.
- R3: Phase bits 21:16 form the table address a and bits 15:10 the weight f. Table entry i (0..64) is round(32767*sin(pi*i/128)). The sample is y0 + floor((y1-y0)*f/64), where y0 is the near point and y1 the far point.
- R4: The cosine output uses the same mapping applied to the phase plus 2^22, computed in the same cycle as the sine.
- R5: Both outputs stay within -32767..32767 and never take the value -32768.
- R6: The sample shown after rising edge m belongs to the phase register value held before edge m-2. The first valid sample therefore belongs to phase 0 (sine 0, cosine 32767).
- R7: The reset input passes through two flip-flops. Once the reset input is sampled low, the valid strobe is low after the 2nd, 3rd and 4th rising edges and rises on the 5th. A reset lasting a single clock edge still restarts the block.
- R8: While the synchronised reset is high, the phase register, both outputs and the valid strobe are zero. Once high, the valid strobe stays high until the next reset.
- R9: A tuning word of zero holds both outputs constant at sine 0 and cosine 32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstIn | input | 1 | Reset request, active high, may be asynchronous to clk |
| tuneWord | input | 24 | Phase increment per clock |
| sinOut | output | 16 | Signed sine sample |
| cosOut | output | 16 | Signed cosine sample |
| sampleValid | output | 1 | High once the pipeline carries real samples |

## Verification
The bench drives tuning words that land exactly on quarter boundaries, where a mirrored lookup taken at the wrong index returns a neighbouring point instead of the peak. It also drives words whose weight steps one unit per sample; a wrong slice of the phase or a missing floor would move every blended sample away from the linear value. A descending tuning word and large words push the phase through every quarter. A swapped sign rule or a cosine offset in the wrong direction would then show as inverted or shifted waveforms. Short single-edge reset pulses, long resets and mid-run tuning changes expose an extra or missing synchroniser stage or pipeline register: either would move the valid edge or the sample alignment by a cycle.

// File: rtl/dds_pkg.sv
package dds_pkg;

  typedef enum logic [1:0] {
    QUAD_RISE     = 2'd0,
    QUAD_FALL     = 2'd1,
    QUAD_NEG_RISE = 2'd2,
    QUAD_NEG_FALL = 2'd3
  } quadrant_e;

  typedef struct packed {
    logic clearPipe;
    logic runAcc;
  } ddsCtl_t;

  // Quarter-wave sample i of 2^addrBits steps, scaled to the largest
  // positive value of an ampBits-wide signed number (odd Taylor series).
  function automatic int quarterSample(int idx, int addrBits, int ampBits);
    real x;
    real term;
    real sum;
    real scale;
    int  steps;
    int  peak;
    int  rounded;
    steps = 1 << addrBits;
    peak  = (1 << (ampBits - 1)) - 1;
    x     = 1.5707963267948966 * real'(idx) / real'(steps);
    term  = x;
    sum   = x;
    for (int k = 1; k <= 7; k++) begin
      term = -term * x * x / real'((2 * k) * (2 * k + 1));
      sum  = sum + term;
    end
    scale   = real'(peak);
    rounded = $rtoi(sum * scale + 0.5);
    if (rounded > peak) rounded = peak;
    if (rounded < 0) rounded = 0;
    return rounded;
  endfunction

endpackage

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
  parameter int ADDR_W = 6,
  parameter int AMP_W  = 16,
  parameter int PORTS  = 2
) (
  input  logic                           clk,
  input  logic [PORTS-1:0][ADDR_W:0]     nearIdx,
  input  logic [PORTS-1:0][ADDR_W:0]     farIdx,
  output logic [PORTS-1:0][AMP_W-2:0]    nearVal,
  output logic [PORTS-1:0][AMP_W-2:0]    farVal
);
  localparam int IDX_W  = ADDR_W + 1;
  localparam int MAG_W  = AMP_W - 1;
  localparam int POINTS = (1 << ADDR_W) + 1;
  localparam int SLOTS  = 1 << IDX_W;

  logic [MAG_W-1:0] waveTbl [SLOTS];

  // Points 0..2^ADDR_W hold the quarter wave; unused slots read as zero.
  for (genvar i = 0; i < SLOTS; i++) begin : g_point
    if (i < POINTS) begin : g_used
      localparam int PointVal = dds_pkg::quarterSample(i, ADDR_W, AMP_W);
      assign waveTbl[i] = MAG_W'(PointVal);
    end else begin : g_spare
      assign waveTbl[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      nearVal[p] <= waveTbl[nearIdx[p]];
      farVal[p]  <= waveTbl[farIdx[p]];
    end
  end

endmodule

// File: rtl/dds_control.sv
module dds_control #(
  parameter int SYNC_STAGES = 2,
  parameter int PIPE_DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rstIn,
  output dds_pkg::ddsCtl_t  ctl,
  output logic              validOut
);
  localparam int CNT_W = $clog2(PIPE_DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PIPE_DEPTH);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   rstSync;
  logic [CNT_W-1:0]       fillCnt;

  always_ff @(posedge clk) begin
    syncChain <= {syncChain[SYNC_STAGES-2:0], rstIn};
  end

  assign rstSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rstSync) begin
      fillCnt <= '0;
    end else if (fillCnt != FULL_CNT) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  assign ctl.clearPipe = rstSync;
  assign ctl.runAcc    = !rstSync;
  assign validOut      = (fillCnt == FULL_CNT);

  // R7: the synchronised reset drops the valid strobe on the next edge
  p_valid_drop_r7: assert property (@(posedge clk)
    rstSync |=> !validOut);

  // R8: valid holds until a reset arrives
  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (rstSync)
    validOut |=> validOut);

endmodule

// File: rtl/dds_datapath.sv
module dds_datapath #(
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 6,
  parameter int FRAC_W  = 6,
  parameter int AMP_W   = 16
) (
  input  logic                     clk,
  input  dds_pkg::ddsCtl_t         ctl,
  input  logic [PHASE_W-1:0]       tuneWord,
  output logic signed [AMP_W-1:0]  sinOut,
  output logic signed [AMP_W-1:0]  cosOut
);
  import dds_pkg::*;

  localparam int CH       = 2;
  localparam int IDX_W    = ADDR_W + 1;
  localparam int MAG_W    = AMP_W - 1;
  localparam int ADDR_LSB = PHASE_W - 2 - ADDR_W;
  localparam int WIDE_W   = AMP_W + FRAC_W + 1;
  localparam logic [PHASE_W-1:0] QUARTER   = {2'b01, {(PHASE_W-2){1'b0}}};
  localparam logic [IDX_W-1:0]   TOP_POINT = IDX_W'(1 << ADDR_W);
  localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

  // Stage 0: phase register
  logic [PHASE_W-1:0] phaseAcc;

  always_ff @(posedge clk) begin
    if (ctl.clearPipe) begin
      phaseAcc <= '0;
    end else if (ctl.runAcc) begin
      phaseAcc <= phaseAcc + tuneWord;
    end
  end

  // Fold: quarter decode, mirrored addressing, weight slice
  logic [CH-1:0][PHASE_W-1:0] chPhase;
  logic [CH-1:0][IDX_W-1:0]   nearIdxC, farIdxC;
  logic [CH-1:0][FRAC_W-1:0]  fracC;
  logic [CH-1:0]              negC;

  assign chPhase[0] = phaseAcc;
  assign chPhase[1] = phaseAcc + QUARTER;

  always_comb begin
    for (int c = 0; c < CH; c++) begin
      quadrant_e         quad;
      logic [IDX_W-1:0]  addrX;
      logic              mirror;
      quad       = quadrant_e'(chPhase[c][PHASE_W-1 -: 2]);
      addrX      = {1'b0, chPhase[c][PHASE_W-3 -: ADDR_W]};
      mirror     = (quad == QUAD_FALL) || (quad == QUAD_NEG_FALL);
      negC[c]    = (quad == QUAD_NEG_RISE) || (quad == QUAD_NEG_FALL);
      fracC[c]   = chPhase[c][ADDR_LSB-1 -: FRAC_W];
      if (mirror) begin
        nearIdxC[c] = TOP_POINT - addrX;
        farIdxC[c]  = TOP_POINT - addrX - 1'b1;
      end else begin
        nearIdxC[c] = addrX;
        farIdxC[c]  = addrX + 1'b1;
      end
    end
  end

  // Stage 1: registered table addresses and per-channel side data
  logic [CH-1:0][IDX_W-1:0]  nearIdxQ, farIdxQ;
  logic [CH-1:0][FRAC_W-1:0] fracQ1, fracQ2;
  logic [CH-1:0]             negQ1, negQ2;

  always_ff @(posedge clk) begin
    if (ctl.clearPipe) begin
      nearIdxQ <= '0;
      farIdxQ  <= '0;
      fracQ1   <= '0;
      negQ1    <= '0;
      fracQ2   <= '0;
      negQ2    <= '0;
    end else begin
      nearIdxQ <= nearIdxC;
      farIdxQ  <= farIdxC;
      fracQ1   <= fracC;
      negQ1    <= negC;
      fracQ2   <= fracQ1;
      negQ2    <= negQ1;
    end
  end

  // Stage 2: dual-port quarter table
  logic [CH-1:0][MAG_W-1:0] nearVal, farVal;

  dds_quarter_rom #(
    .ADDR_W (ADDR_W),
    .AMP_W  (AMP_W),
    .PORTS  (CH)
  ) u_rom (
    .clk     (clk),
    .nearIdx (nearIdxQ),
    .farIdx  (farIdxQ),
    .nearVal (nearVal),
    .farVal  (farVal)
  );

  // Stage 3: linear blend and sign restore
  logic signed [AMP_W-1:0] blendC [CH];
  logic signed [AMP_W-1:0] outQ   [CH];

  always_comb begin
    for (int c = 0; c < CH; c++) begin
      logic signed [AMP_W-1:0]  baseV;
      logic signed [AMP_W-1:0]  diffV;
      logic signed [WIDE_W-1:0] prodV;
      logic signed [AMP_W-1:0]  stepV;
      logic signed [AMP_W-1:0]  mixV;
      baseV = $signed({1'b0, nearVal[c]});
      diffV = $signed({1'b0, farVal[c]}) - baseV;
      prodV = WIDE_W'(diffV) * WIDE_W'($signed({1'b0, fracQ2[c]}));
      stepV = AMP_W'(prodV >>> FRAC_W);
      mixV  = baseV + stepV;
      blendC[c] = negQ2[c] ? -mixV : mixV;
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < CH; c++) begin
      if (ctl.clearPipe) begin
        outQ[c] <= '0;
      end else begin
        outQ[c] <= blendC[c];
      end
    end
  end

  assign sinOut = outQ[0];
  assign cosOut = outQ[1];

  // Helpers for the checks below
  logic [MAG_W-1:0] sinMag;
  logic [MAG_W-1:0] pairLo, pairHi;
  assign sinMag = sinOut[AMP_W-1] ? MAG_W'(-sinOut) : MAG_W'(sinOut);
  assign pairLo = (nearVal[0] < farVal[0]) ? nearVal[0] : farVal[0];
  assign pairHi = (nearVal[0] < farVal[0]) ? farVal[0] : nearVal[0];

  // R3: the blended magnitude stays between the two table points read
  p_blend_bounded_r3: assert property (@(posedge clk) disable iff (ctl.clearPipe)
    ctl.runAcc |=> (sinMag >= $past(pairLo)) && (sinMag <= $past(pairHi)));

  // R2: negating quarters yield non-positive samples
  p_neg_quarter_r2: assert property (@(posedge clk) disable iff (ctl.clearPipe)
    negQ2[0] |=> (sinOut <= 0));

  // R2: non-negating quarters yield non-negative samples
  p_pos_quarter_r2: assert property (@(posedge clk) disable iff (ctl.clearPipe)
    !negQ2[0] |=> (sinOut >= 0));

  // R5: the most negative code never appears
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (ctl.clearPipe)
    ctl.runAcc |-> (sinOut != MOST_NEG) && (cosOut != MOST_NEG));

endmodule

// File: rtl/sincos_interp_dds.sv
module sincos_interp_dds #(
  parameter int PHASE_W     = 24,
  parameter int ADDR_W      = 6,
  parameter int FRAC_W      = 6,
  parameter int AMP_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstIn,
  input  logic [PHASE_W-1:0]       tuneWord,
  output logic signed [AMP_W-1:0]  sinOut,
  output logic signed [AMP_W-1:0]  cosOut,
  output logic                     sampleValid
);
  // Fold register, table register, blend register
  localparam int PIPE_DEPTH = 3;

  dds_pkg::ddsCtl_t ctl;

  dds_control #(
    .SYNC_STAGES (SYNC_STAGES),
    .PIPE_DEPTH  (PIPE_DEPTH)
  ) u_ctrl (
    .clk      (clk),
    .rstIn    (rstIn),
    .ctl      (ctl),
    .validOut (sampleValid)
  );

  dds_datapath #(
    .PHASE_W (PHASE_W),
    .ADDR_W  (ADDR_W),
    .FRAC_W  (FRAC_W),
    .AMP_W   (AMP_W)
  ) u_dp (
    .clk      (clk),
    .ctl      (ctl),
    .tuneWord (tuneWord),
    .sinOut   (sinOut),
    .cosOut   (cosOut)
  );

  // R8: a cleared pipeline shows zero on both outputs
  p_clear_outputs_r8: assert property (@(posedge clk)
    ctl.clearPipe |=> (sinOut == 0) && (cosOut == 0));

endmodule

// File: tb/sincos_interp_dds_test.sv
`timescale 1ns/1ps
module sincos_interp_dds_test;

  localparam int HALF = 10;  // 50 MHz

  typedef struct packed {
    logic [23:0] tune;
    logic [15:0] steps;
    logic [3:0]  tagSel;   // 1:R1 2:R2 3:R3 9:R9
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{24'h000000, 16'd40, 4'd9},
    '{24'h400000, 16'd40, 4'd2},
    '{24'h800000, 16'd30, 4'd2},
    '{24'h000400, 16'd80, 4'd3},
    '{24'h012345, 16'd80, 4'd1},
    '{24'hFFF000, 16'd80, 4'd1},
    '{24'h1ABCDE, 16'd80, 4'd2},
    '{24'h3FFFFF, 16'd60, 4'd3}
  };

  logic              clk = 1'b0;
  logic              rstIn = 1'b1;
  logic [23:0]       tuneWord = '0;
  logic signed [15:0] sinOut, cosOut;
  logic              sampleValid;

  int checks = 0;
  int fails  = 0;
  int tbl [65];

  // bench model state
  logic [23:0] modelAcc = '0;
  logic [23:0] h0 = '0, h1 = '0, h2 = '0;
  int edgesSince = 0;
  int rstEdges = 0;
  string sampleTag = "R1";

  always #HALF clk = ~clk;

  sincos_interp_dds uut (
    .clk         (clk),
    .rstIn       (rstIn),
    .tuneWord    (tuneWord),
    .sinOut      (sinOut),
    .cosOut      (cosOut),
    .sampleValid (sampleValid)
  );

  function automatic int refWave(logic [23:0] ph);
    int q, a, f, y0, y1, v;
    q = int'(ph[23:22]);
    a = int'(ph[21:16]);
    f = int'(ph[15:10]);
    if (q == 1 || q == 3) begin
      y0 = tbl[64 - a];
      y1 = tbl[63 - a];
    end else begin
      y0 = tbl[a];
      y1 = tbl[a + 1];
    end
    v = y0 + (((y1 - y0) * f) >>> 6);
    if (q >= 2) v = -v;
    return v;
  endfunction

  task automatic checkNear(input string tag, input string what, input int act, input int exp);
    int d;
    checks++;
    d = act - exp;
    if (d > 1 || d < -1 || act == -32768) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, model the rising edge, check later.
  task automatic step(input logic [23:0] t, input logic r);
    @(negedge clk);
    tuneWord = t;
    rstIn    = r;
    @(posedge clk);
    if (r) begin
      edgesSince = 0;
      rstEdges++;
    end else begin
      edgesSince++;
      rstEdges = 0;
    end
    h2 = h1;
    h1 = h0;
    h0 = modelAcc;
    if (edgesSince >= 3) modelAcc = modelAcc + t;
    else modelAcc = '0;
    #(HALF / 2);
    if (rstEdges >= 3) begin
      checkBit("R8", "valid in reset", sampleValid, 1'b0);
      checkNear("R8", "sine in reset", int'(sinOut), 0);
      checkNear("R8", "cosine in reset", int'(cosOut), 0);
    end
    if (edgesSince >= 2 && edgesSince < 5) begin
      checkBit("R7", "valid during fill", sampleValid, 1'b0);
    end else if (edgesSince >= 5) begin
      checkBit("R7", "valid after fill", sampleValid, 1'b1);
      if (edgesSince == 5) begin
        checkNear("R6", "first sine", int'(sinOut), 0);
        checkNear("R6", "first cosine", int'(cosOut), 32767);
      end
      checkNear(sampleTag, "sine", int'(sinOut), refWave(h2));
      checkNear("R4", "cosine", int'(cosOut), refWave(h2 + 24'h400000));
      checkNear("R5", "sine range", int'(sinOut), int'(sinOut) > 32767 ? 32767 : int'(sinOut));
    end
  endtask

  task automatic doReset(input int n);
    for (int i = 0; i < n; i++) step(tuneWord, 1'b1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    for (int i = 0; i <= 64; i++)
      tbl[i] = $rtoi(32767.0 * $sin(3.141592653589793 * real'(i) / 128.0) + 0.5);

    // Vector table walk: reset, then run each tuning word
    for (int v = 0; v < 8; v++) begin
      case (VECS[v].tagSel)
        4'd2: sampleTag = "R2";
        4'd3: sampleTag = "R3";
        4'd9: sampleTag = "R9";
        default: sampleTag = "R1";
      endcase
      doReset(4);
      for (int s = 0; s < int'(VECS[v].steps); s++) step(VECS[v].tune, 1'b0);
    end

    // R9: zero tuning word gives a flat waveform
    sampleTag = "R9";
    doReset(4);
    for (int s = 0; s < 12; s++) step(24'h000000, 1'b0);
    checkNear("R9", "flat sine", int'(sinOut), 0);
    checkNear("R9", "flat cosine", int'(cosOut), 32767);

    // R1: tuning word changes every cycle mid-run
    sampleTag = "R1";
    for (int s = 0; s < 60; s++) step(24'h020000 + 24'(s * 24'h013579), 1'b0);

    // R7: single-edge reset pulse during a run restarts the block
    for (int s = 0; s < 10; s++) step(24'h0F0F0F, 1'b0);
    step(24'h0F0F0F, 1'b1);
    for (int s = 0; s < 20; s++) step(24'h0F0F0F, 1'b0);

    // R2: quarter-step boundary again after a long reset
    sampleTag = "R2";
    doReset(6);
    for (int s = 0; s < 16; s++) step(24'h400000, 1'b0);

    // R3: one weight unit per sample across a mirrored quarter
    sampleTag = "R3";
    doReset(3);
    for (int s = 0; s < 8; s++) step(24'h3F0000, 1'b0);
    for (int s = 0; s < 70; s++) step(24'h000400, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule